// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Unit

This block holds two pending bitmaps, one bit per processor, for up to `MAX_CPUS` processors. The first bitmap holds inter-processor interrupts. Software raises them by writing a processor mask to a request register and drops them through a clear register. The second bitmap holds interval-timer interrupts. A periodic tick input raises a timer interrupt on every active processor. Software drops timer interrupts through one of two paths: a dedicated timer-clear register, or a mask field in a miscellaneous control register.

Each pending bit drives its own registered interrupt line. The inter-processor lines are the level-3 requests. The timer lines are the level-2 requests. Three one-cycle pulse flags report what each write did: a warning for a redundant request or a redundant clear, an error for an all-zero mask or an unsupported miscellaneous write, and an acknowledge for a non-existent-memory error. Only the processors below `ACTIVE_CPUS` are affected. The surrounding bus logic presents each write as one cycle of `wr_en` with a register select and a data word.

Top module: `ipi_tmr_irq`

## Requirements
- R1: A write with `wr_sel`=0 (request) sets the inter-processor pending bit of each active processor whose bit is set in `wr_data[MAX_CPUS-1:0]`. The matching `ipi_irq_o` bit is high after the next clock edge.
- R2: When a request names an active processor whose inter-processor bit is already set, no bitmap changes for that processor, and `warn_o` pulses high for one cycle.
- R3: A write with `wr_sel`=1 (clear) clears the inter-processor pending bit of each masked active processor. The matching `ipi_irq_o` bit goes low after the next clock edge.
- R4: When a clear with `wr_sel`=1 names an active processor whose inter-processor bit is not set, `warn_o` pulses high for one cycle.
- R5: A write with `wr_sel`=2 (timer clear) clears the timer bit only for processors that are both masked and pending. It leaves the other timer bits as they were and raises no warning.
- R6: A write with `wr_sel` of 0, 1 or 2 whose `wr_data[MAX_CPUS-1:0]` is zero pulses `err_o` for one cycle and changes neither bitmap.
- R7: `tick_i` sets the timer pending bit of every active processor. When a tick and a timer clear arrive in the same cycle, the tick wins.
- R8: A write with `wr_sel`=3 (miscellaneous) clears the timer bits named by `wr_data[7:4]`. If `wr_data[28]` is set, it also pulses `nxm_ack_o` for one cycle.
- R9: A miscellaneous write with `wr_data[7:4]` zero and `wr_data[28]` clear pulses `err_o` and changes nothing.
- R10: Mask bits at or above `ACTIVE_CPUS` are ignored. The interrupt outputs of those processors stay low at all times, and a mask naming only such processors raises neither warning nor error.
- R11: After reset, both bitmaps, all interrupt outputs and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Target register: 0 request, 1 clear, 2 timer clear, 3 miscellaneous |
| wr_data | input | DATA_W | Write data |
| tick_i | input | 1 | Periodic timer tick |
| ipi_irq_o | output | MAX_CPUS | Level-3 inter-processor interrupt per processor |
| tmr_irq_o | output | MAX_CPUS | Level-2 timer interrupt per processor |
| warn_o | output | 1 | Pulse: redundant request or redundant clear |
| err_o | output | 1 | Pulse: zero mask or unsupported miscellaneous write |
| nxm_ack_o | output | 1 | Pulse: non-existent-memory acknowledge |

## Verification
The assertions check four things on every cycle: a request leaves every named processor pending, a clear leaves every named processor idle, a redundant request leaves the bitmap untouched, and a tick fills the timer bitmap. They also check that processors above the active count never show an interrupt and that a zero-mask write freezes both bitmaps. Some behaviour only the bench's scenarios can show. These are the exact warning and error pulses for each register path, the selective timer clear through both paths, the tick-over-clear priority, and the return to zero on reset from a loaded state.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;
   typedef enum logic [1:0] {
      SEL_IPI_REQ = 2'd0,
      SEL_IPI_CLR = 2'd1,
      SEL_TMR_CLR = 2'd2,
      SEL_MISC    = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/ipi_tmr_decode.sv
module ipi_tmr_decode #(
   parameter int MAX_CPUS     = 4,
   parameter int ACTIVE_CPUS  = 4,
   parameter int DATA_W       = 32,
   parameter int TCLR_LSB     = 4,
   parameter int NXM_BIT      = 28
) (
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [MAX_CPUS-1:0] ipi_set,
   output logic [MAX_CPUS-1:0] ipi_clr,
   output logic [MAX_CPUS-1:0] tmr_clr,
   output logic                bad_write,
   output logic                nxm_hit
);
   import ipi_tmr_pkg::*;

   logic [MAX_CPUS-1:0] act;
   for (genvar i = 0; i < MAX_CPUS; i++) begin : g_act
      assign act[i] = (i < ACTIVE_CPUS);
   end

   logic [MAX_CPUS-1:0] low_mask, misc_mask;
   logic                misc_nxm;
   reg_sel_e            sel;

   assign sel       = reg_sel_e'(wr_sel);
   assign low_mask  = wr_data[MAX_CPUS-1:0];
   assign misc_mask = wr_data[TCLR_LSB +: MAX_CPUS];
   assign misc_nxm  = wr_data[NXM_BIT];

   always_comb begin
      ipi_set   = '0;
      ipi_clr   = '0;
      tmr_clr   = '0;
      bad_write = 1'b0;
      nxm_hit   = 1'b0;
      if (wr_en) begin
         unique case (sel)
            SEL_IPI_REQ: begin
               ipi_set   = low_mask & act;
               bad_write = (low_mask == '0);
            end
            SEL_IPI_CLR: begin
               ipi_clr   = low_mask & act;
               bad_write = (low_mask == '0);
            end
            SEL_TMR_CLR: begin
               tmr_clr   = low_mask & act;
               bad_write = (low_mask == '0);
            end
            SEL_MISC: begin
               tmr_clr   = misc_mask & act;
               nxm_hit   = misc_nxm;
               bad_write = (misc_mask == '0) && !misc_nxm;
            end
         endcase
      end
   end
endmodule

// File: rtl/ipi_bank.sv
module ipi_bank #(
   parameter int MAX_CPUS    = 4,
   parameter int ACTIVE_CPUS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [MAX_CPUS-1:0] set_m,
   input  logic [MAX_CPUS-1:0] clr_m,
   output logic [MAX_CPUS-1:0] pend,
   output logic                redundant
);
   for (genvar i = 0; i < MAX_CPUS; i++) begin : g_bit
      if (i < ACTIVE_CPUS) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)        pend[i] <= 1'b0;
            else if (set_m[i]) pend[i] <= 1'b1;
            else if (clr_m[i]) pend[i] <= 1'b0;
         end
      end else begin : g_dead
         assign pend[i] = 1'b0;
      end
   end

   assign redundant = |(set_m & pend) | |(clr_m & ~pend);

   a_r1_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_m) |=> ((pend & $past(set_m)) == $past(set_m)));
   a_r2_dup_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_m & ~pend) == '0 && clr_m == '0) |=> $stable(pend));
   a_r3_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_m) |=> ((pend & $past(clr_m)) == '0));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
   parameter int MAX_CPUS    = 4,
   parameter int ACTIVE_CPUS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [MAX_CPUS-1:0] clr_m,
   output logic [MAX_CPUS-1:0] pend
);
   for (genvar i = 0; i < MAX_CPUS; i++) begin : g_bit
      if (i < ACTIVE_CPUS) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)        pend[i] <= 1'b0;
            else if (tick)     pend[i] <= 1'b1;
            else if (clr_m[i]) pend[i] <= 1'b0;
         end
      end else begin : g_dead
         assign pend[i] = 1'b0;
      end
   end

   a_r7_tick_fills: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ($countones(pend) == ACTIVE_CPUS));
   a_r5_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && |clr_m) |=> ((pend & $past(clr_m)) == '0));
endmodule

// File: rtl/ipi_tmr_irq.sv
module ipi_tmr_irq #(
   parameter int MAX_CPUS    = 4,
   parameter int ACTIVE_CPUS = 4,
   parameter int DATA_W      = 32,
   parameter int TCLR_LSB    = 4,
   parameter int NXM_BIT     = 28
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                tick_i,
   output logic [MAX_CPUS-1:0] ipi_irq_o,
   output logic [MAX_CPUS-1:0] tmr_irq_o,
   output logic                warn_o,
   output logic                err_o,
   output logic                nxm_ack_o
);
   localparam int TCLR_MSB = TCLR_LSB + MAX_CPUS - 1;

   if (ACTIVE_CPUS < 1 || ACTIVE_CPUS > MAX_CPUS) begin : g_bad_active
      initial $fatal(1, "ACTIVE_CPUS must be within 1..MAX_CPUS");
   end
   if (TCLR_MSB >= DATA_W || NXM_BIT >= DATA_W || MAX_CPUS > TCLR_LSB) begin : g_bad_fields
      initial $fatal(1, "register fields do not fit DATA_W or overlap");
   end

   logic [MAX_CPUS-1:0] ipi_set, ipi_clr, tmr_clr;
   logic                bad_write, nxm_hit, redundant;

   ipi_tmr_decode #(
      .MAX_CPUS(MAX_CPUS), .ACTIVE_CPUS(ACTIVE_CPUS), .DATA_W(DATA_W),
      .TCLR_LSB(TCLR_LSB), .NXM_BIT(NXM_BIT)
   ) u_dec (
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ipi_set(ipi_set), .ipi_clr(ipi_clr), .tmr_clr(tmr_clr),
      .bad_write(bad_write), .nxm_hit(nxm_hit)
   );

   ipi_bank #(.MAX_CPUS(MAX_CPUS), .ACTIVE_CPUS(ACTIVE_CPUS)) u_ipi (
      .clk(clk), .rst_n(rst_n), .set_m(ipi_set), .clr_m(ipi_clr),
      .pend(ipi_irq_o), .redundant(redundant)
   );

   tmr_bank #(.MAX_CPUS(MAX_CPUS), .ACTIVE_CPUS(ACTIVE_CPUS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .clr_m(tmr_clr),
      .pend(tmr_irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         warn_o    <= 1'b0;
         err_o     <= 1'b0;
         nxm_ack_o <= 1'b0;
      end else begin
         warn_o    <= redundant;
         err_o     <= bad_write;
         nxm_ack_o <= nxm_hit;
      end
   end

   a_r6_zero_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != 2'd3 && wr_data[MAX_CPUS-1:0] == '0 && !tick_i)
      |=> (err_o && $stable(ipi_irq_o) && $stable(tmr_irq_o)));
   a_r10_idle_cpus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((ipi_irq_o | tmr_irq_o) >> ACTIVE_CPUS) == '0);
   a_r9_misc_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && wr_data[TCLR_MSB:TCLR_LSB] == '0 && !wr_data[NXM_BIT])
      |=> (err_o && !nxm_ack_o));
endmodule

// File: tb/tb_ipi_tmr_irq.sv
module tb_ipi_tmr_irq;
   localparam int MAXC = 4;
   localparam int ACTC = 3;
   localparam int NV   = 18;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [1:0]      wr_sel = 2'd0;
   logic [31:0]     wr_data = '0;
   logic            tick_i = 1'b0;
   logic [MAXC-1:0] ipi_irq_o, tmr_irq_o;
   logic            warn_o, err_o, nxm_ack_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   ipi_tmr_irq #(.MAX_CPUS(MAXC), .ACTIVE_CPUS(ACTC)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .tick_i(tick_i), .ipi_irq_o(ipi_irq_o),
      .tmr_irq_o(tmr_irq_o), .warn_o(warn_o), .err_o(err_o),
      .nxm_ack_o(nxm_ack_o)
   );

   // {tick, wr, sel[1:0], data[31:0], ipi[3:0], tmr[3:0], warn, err, nxm}
   localparam logic [46:0] VEC [NV] = '{
      {1'b0,1'b1,2'd0,32'h0000_0003,4'b0011,4'b0000,3'b000}, // R1 request
      {1'b0,1'b1,2'd0,32'h0000_0006,4'b0111,4'b0000,3'b100}, // R2 duplicate cpu1
      {1'b0,1'b1,2'd1,32'h0000_0001,4'b0110,4'b0000,3'b000}, // R3 clear
      {1'b0,1'b1,2'd1,32'h0000_0001,4'b0110,4'b0000,3'b100}, // R4 clear not pending
      {1'b0,1'b1,2'd0,32'h0000_0000,4'b0110,4'b0000,3'b010}, // R6 zero request
      {1'b0,1'b1,2'd0,32'h0000_0008,4'b0110,4'b0000,3'b000}, // R10 inactive cpu only
      {1'b1,1'b0,2'd0,32'h0000_0000,4'b0110,4'b0111,3'b000}, // R7 tick
      {1'b0,1'b1,2'd2,32'h0000_0005,4'b0110,4'b0010,3'b000}, // R5 timer clear
      {1'b0,1'b1,2'd2,32'h0000_0001,4'b0110,4'b0010,3'b000}, // R5 not pending, no warn
      {1'b0,1'b1,2'd2,32'h0000_0000,4'b0110,4'b0010,3'b010}, // R6 zero timer clear
      {1'b1,1'b1,2'd2,32'h0000_0002,4'b0110,4'b0111,3'b000}, // R7 tick beats clear
      {1'b0,1'b1,2'd3,32'h1000_0020,4'b0110,4'b0101,3'b001}, // R8 misc clear + ack
      {1'b0,1'b1,2'd3,32'h0000_0001,4'b0110,4'b0101,3'b010}, // R9 unsupported misc
      {1'b0,1'b1,2'd3,32'h1000_0000,4'b0110,4'b0101,3'b001}, // R8 ack only
      {1'b0,1'b1,2'd3,32'h0000_0040,4'b0110,4'b0001,3'b000}, // R8 misc clear cpu2
      {1'b0,1'b0,2'd0,32'h0000_0000,4'b0110,4'b0001,3'b000}, // idle, flags drop
      {1'b0,1'b1,2'd1,32'h0000_0006,4'b0000,4'b0001,3'b000}, // R3 multi clear
      {1'b0,1'b1,2'd1,32'h0000_0000,4'b0000,4'b0001,3'b010}  // R6 zero clear
   };

   task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got ipi/tmr/w/e/n=%b expected %b", tag, act, exp);
      end
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset", {ipi_irq_o, tmr_irq_o, warn_o, err_o, nxm_ack_o}, '0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         tick_i  = VEC[i][46];
         wr_en   = VEC[i][45];
         wr_sel  = VEC[i][44:43];
         wr_data = VEC[i][42:11];
         @(posedge clk);
         @(negedge clk);
         tick_i = 1'b0; wr_en = 1'b0;
         check($sformatf("vector %0d", i),
               {ipi_irq_o, tmr_irq_o, warn_o, err_o, nxm_ack_o}, VEC[i][10:0]);
      end
      // R10 tick with inactive cpu: bit 3 stays low
      tick_i = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'hF;
      @(posedge clk); @(negedge clk);
      tick_i = 1'b0; wr_en = 1'b0;
      check("R10 all-ones mask", {ipi_irq_o, tmr_irq_o, warn_o, err_o, nxm_ack_o},
            {4'b0111, 4'b0111, 3'b000});
      // R11 reset from loaded state
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R11 reset loaded", {ipi_irq_o, tmr_irq_o, warn_o, err_o, nxm_ack_o}, '0);
      rst_n = 1'b1;
      // R2 duplicate right after reset is not duplicate
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h4;
      @(posedge clk); @(negedge clk);
      check("R2 fresh request", {ipi_irq_o, tmr_irq_o, warn_o, err_o, nxm_ack_o},
            {4'b0100, 4'b0000, 3'b000});
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      check("R2 repeat request", {ipi_irq_o, tmr_irq_o, warn_o, err_o, nxm_ack_o},
            {4'b0100, 4'b0000, 3'b100});
      @(posedge clk); @(negedge clk);
      check("R2 warn one cycle", {ipi_irq_o, tmr_irq_o, warn_o, err_o, nxm_ack_o},
            {4'b0100, 4'b0000, 3'b000});
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule